// File: doc/BRIEF.md
# Interrupt Status and Mask Register Block

This block sits between the event outputs of a two-wire bus controller core and a host register port. Every event source owns one bit in a 10-bit source vector. A status register records the sources, and a mask register decides which of them may raise the single interrupt line. Two kinds of status bit exist. Sticky bits latch on a one-cycle event and hold until the host writes a one to them. Level bits follow their condition input and take no notice of host writes.

The host never writes the mask directly. It writes ones to an enable strobe register to unmask sources, and ones to a disable strobe register to mask them. The mask polarity is inverted: a 1 blocks the source. After reset every implemented source is blocked. The interrupt output is registered. It is updated on the same clock edge as the status and mask registers it is derived from.

Top module: `irq_regblock`

## Requirements
- R1: Reset is synchronous and active high. After reset the status register reads 0x000, the mask register reads 0x2FF and `irq_o` is 0.
- R2: Bits 9, 6, 5, 4, 3, 2 and 0 are sticky. A one-cycle event on `evt_i[i]` sets status bit i at the next clock edge, and the bit stays set after the event ends.
- R3: A write to the status register (offset 0x10) clears every sticky bit whose write-data bit is 1. Sticky bits whose write-data bit is 0 keep their value.
- R4: If an event on a sticky bit arrives in the same cycle as a write-one-clear of that bit, the bit stays set.
- R5: Bits 1 (data) and 7 (receive underflow) are level bits. Each one equals the value its event input had in the previous cycle. A write of 1 to the status register does not clear it while the input stays high.
- R6: A write to the enable register (offset 0x24) clears every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 are unchanged.
- R7: A write to the disable register (offset 0x28) sets every implemented mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 are unchanged.
- R8: `irq_o` is 1 exactly when (status & ~mask & 0x2FF) is non-zero. It changes on the same clock edge as the status or mask bit that causes the change.
- R9: Bit 8 is unimplemented and always reads 0 in both status and mask, even when `evt_i[8]` pulses. Reading offset 0x24, offset 0x28 or any unmapped offset returns 0.
- R10: The mask register (offset 0x20) is read-only. A write to 0x20 or to 0x10 leaves the mask unchanged.
- R11: A read with `rd_en` high returns, after the next clock edge, the value the addressed register held before that edge. `rdata` then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 8 | Host register byte offset |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Registered host read data |
| evt_i | input | 10 | Source events (pulses for sticky bits, levels for level bits) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Each of the ten bit positions is driven on its own. This shows whether the bit is latched, followed or dropped, and whether the sticky and level kinds have been swapped at any position. For every bit, three writes are applied: a clear with that bit at 0, a clear racing a new event, and a plain clear. These separate write-one-to-clear from write-zero-to-clear and show which side wins the race. Enable and disable writes use single-bit, all-ones and zero patterns, so a swapped polarity or a write that reaches other bits shows up on the mask readback and on `irq_o`. Reads of the strobe registers and of an unmapped offset, plus writes aimed at the read-only mask, show whether the address decode leaks.

// File: rtl/irq_regblock_pkg.sv
package irq_regblock_pkg;

  localparam int SRC_W  = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    KIND_UNUSED = 2'd0,
    KIND_LEVEL  = 2'd1,
    KIND_STICKY = 2'd2
  } src_kind_e;

  // Picks the storage variant of one source bit from the two masks.
  function automatic src_kind_e kind_of(input int idx, input logic [31:0] valid,
                                        input logic [31:0] level);
    if (!valid[idx])     return KIND_UNUSED;
    else if (level[idx]) return KIND_LEVEL;
    else                 return KIND_STICKY;
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_regblock_pkg::*;
#(
  parameter src_kind_e KIND = KIND_STICKY
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic clr_i,
  output logic bit_o,
  output logic bit_nxt_o
);

  logic q;
  logic d;

  generate
    if (KIND == KIND_STICKY) begin : g_sticky
      // A new event takes priority over a clear in the same cycle.
      always_comb d = evt_i | (q & ~clr_i);
    end else if (KIND == KIND_LEVEL) begin : g_level
      logic unused_clr;
      always_comb d = evt_i;
      assign unused_clr = clr_i;
    end else begin : g_unused
      logic unused_in;
      always_comb d = 1'b0;
      assign unused_in = evt_i ^ clr_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  assign bit_o     = q;
  assign bit_nxt_o = d;

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int               W     = 10,
  parameter logic [W-1:0]     VALID = 10'h2FF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         unmask_en,
  input  logic         mask_en,
  input  logic [W-1:0] sel,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] mask_nxt_o
);

  logic [W-1:0] q;
  logic [W-1:0] d;

  always_comb begin
    d = q;
    if (unmask_en) d = d & ~sel;
    if (mask_en)   d = d | sel;
    d = d & VALID;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= VALID;
    else     q <= d;
  end

  assign mask_o     = q;
  assign mask_nxt_o = d;

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter int                SRC_W      = 10,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK   = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_W-1:0]  status,
  input  logic [SRC_W-1:0]  mask,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - SRC_W;

  logic [DATA_W-1:0] sel_val;
  logic [DATA_W-1:0] q;

  always_comb begin
    if (addr == OFS_STATUS)    sel_val = {{PAD_W{1'b0}}, status};
    else if (addr == OFS_MASK) sel_val = {{PAD_W{1'b0}}, mask};
    else                       sel_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (rd_en) q <= sel_val;
  end

  assign rdata = q;

endmodule

// File: rtl/irq_regblock.sv
module irq_regblock
  import irq_regblock_pkg::*;
#(
  parameter int                       SRC_W       = irq_regblock_pkg::SRC_W,
  parameter int                       ADDR_W      = irq_regblock_pkg::ADDR_W,
  parameter int                       DATA_W      = irq_regblock_pkg::DATA_W,
  parameter logic [SRC_W-1:0]         VALID_MASK  = 10'h2FF,
  parameter logic [SRC_W-1:0]         LEVEL_MASK  = 10'h082,
  parameter logic [ADDR_W-1:0]        OFS_STATUS  = 8'h10,
  parameter logic [ADDR_W-1:0]        OFS_MASK    = 8'h20,
  parameter logic [ADDR_W-1:0]        OFS_UNMASK  = 8'h24,
  parameter logic [ADDR_W-1:0]        OFS_DOMASK  = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [SRC_W-1:0]  evt_i,
  output logic              irq_o
);

  logic [SRC_W-1:0] wsel;
  logic             wr_status;
  logic             wr_unmask;
  logic             wr_domask;
  logic [SRC_W-1:0] status_q;
  logic [SRC_W-1:0] status_d;
  logic [SRC_W-1:0] clr_vec;
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] mask_d;
  logic             irq_q;

  assign wsel      = wdata[SRC_W-1:0];
  assign wr_status = wr_en && (addr == OFS_STATUS);
  assign wr_unmask = wr_en && (addr == OFS_UNMASK);
  assign wr_domask = wr_en && (addr == OFS_DOMASK);
  assign clr_vec   = wr_status ? wsel : '0;

  generate
    for (genvar i = 0; i < SRC_W; i++) begin : g_src
      localparam src_kind_e K = kind_of(i, 32'(VALID_MASK), 32'(LEVEL_MASK));
      irq_src_cell #(.KIND(K)) u_cell (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i[i]),
        .clr_i     (clr_vec[i]),
        .bit_o     (status_q[i]),
        .bit_nxt_o (status_d[i])
      );
    end
  endgenerate

  irq_mask_bank #(.W(SRC_W), .VALID(VALID_MASK)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .unmask_en  (wr_unmask),
    .mask_en    (wr_domask),
    .sel        (wsel),
    .mask_o     (mask_q),
    .mask_nxt_o (mask_d)
  );

  irq_read_port #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SRC_W      (SRC_W),
    .OFS_STATUS (OFS_STATUS),
    .OFS_MASK   (OFS_MASK)
  ) u_read (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .addr   (addr),
    .status (status_q),
    .mask   (mask_q),
    .rdata  (rdata)
  );

  // Computed from next-state values so the request moves with its cause.
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_d & ~mask_d & VALID_MASK);
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_regblock_chk.sv
module irq_regblock_chk #(
  parameter int                SRC_W      = 10,
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter logic [SRC_W-1:0]  VALID_MASK = 10'h2FF,
  parameter logic [SRC_W-1:0]  LEVEL_MASK = 10'h082,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_UNMASK = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_DOMASK = 8'h28
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [SRC_W-1:0]  evt_i,
  input logic              irq_o,
  input logic [SRC_W-1:0]  status_q,
  input logic [SRC_W-1:0]  mask_q
);

  localparam logic [SRC_W-1:0] STICKY = VALID_MASK & ~LEVEL_MASK;

  logic [SRC_W-1:0] c_clr;
  logic [SRC_W-1:0] c_sel;
  logic             c_unmask;
  logic             c_domask;

  assign c_sel    = wdata[SRC_W-1:0];
  assign c_clr    = (wr_en && addr == OFS_STATUS) ? c_sel : '0;
  assign c_unmask = wr_en && addr == OFS_UNMASK;
  assign c_domask = wr_en && addr == OFS_DOMASK;

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(evt_i & STICKY)) == $past(evt_i & STICKY))); // R2

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(status_q & STICKY & ~c_clr)) ==
              $past(status_q & STICKY & ~c_clr))); // R3

  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(c_clr & STICKY & ~evt_i)) == '0)); // R3

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & LEVEL_MASK) == $past(evt_i & LEVEL_MASK))); // R5

  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    c_unmask && !c_domask |=> ((mask_q & $past(c_sel)) == '0)); // R6

  AST_DOMASK_SETS: assert property (@(posedge clk) disable iff (rst)
    c_domask |=> ((mask_q & $past(c_sel & VALID_MASK)) == $past(c_sel & VALID_MASK))); // R7

  AST_MASK_READONLY: assert property (@(posedge clk) disable iff (rst)
    !c_unmask && !c_domask |=> $stable(mask_q)); // R10

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(status_q & ~mask_q & VALID_MASK))); // R8

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((status_q | mask_q) & ~VALID_MASK) == '0); // R9

endmodule

bind irq_regblock irq_regblock_chk #(
  .SRC_W      (SRC_W),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .VALID_MASK (VALID_MASK),
  .LEVEL_MASK (LEVEL_MASK),
  .OFS_STATUS (OFS_STATUS),
  .OFS_UNMASK (OFS_UNMASK),
  .OFS_DOMASK (OFS_DOMASK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .evt_i    (evt_i),
  .irq_o    (irq_o),
  .status_q (status_q),
  .mask_q   (mask_q)
);

// File: tb/test_irq_regblock.sv
`timescale 1ns/1ps
module test_irq_regblock;

  localparam int W = 10;
  localparam logic [W-1:0] VALID = 10'h2FF;
  localparam logic [W-1:0] LEVEL = 10'h082;
  localparam logic [7:0] A_STAT = 8'h10, A_MASK = 8'h20, A_UNM = 8'h24, A_DOM = 8'h28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [W-1:0] evt_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [W-1:0] m_stat;
  logic [W-1:0] m_mask;
  logic [W-1:0] hold;

  always #2 clk = ~clk;

  irq_regblock i_irq_regblock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, let one rising edge pass, update the model.
  task automatic step(input bit w, input bit r, input logic [7:0] a,
                      input logic [31:0] d, input logic [W-1:0] pulse);
    logic [W-1:0] ev;
    logic [W-1:0] sel;
    ev = (pulse | hold);
    sel = d[W-1:0];
    wr_en = w; rd_en = r; addr = a; wdata = d; evt_i = ev;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; wdata = '0; evt_i = hold;
    if (w && a == A_STAT) m_stat = m_stat & ~(sel & ~LEVEL);
    m_stat = ((m_stat & ~LEVEL) | (ev & ~LEVEL) | (ev & LEVEL)) & VALID;
    if (w && a == A_UNM) m_mask = m_mask & ~sel;
    if (w && a == A_DOM) m_mask = (m_mask | sel) & VALID;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    step(0, 1, a, '0, '0);
    check(rdata, exp, tag);
  endtask

  function automatic logic exp_irq();
    return |(m_stat & ~m_mask & VALID);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    m_stat = '0; m_mask = VALID; hold = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check({31'b0, irq_o}, 32'd0, "R1 irq after reset");
    rd_chk(A_STAT, 32'h0, "R1 status after reset");
    rd_chk(A_MASK, 32'h2FF, "R1 mask after reset");

    // R9: strobe registers and an unmapped offset read back zero
    rd_chk(A_UNM, 32'h0, "R9 enable reg reads zero");
    rd_chk(A_DOM, 32'h0, "R9 disable reg reads zero");
    rd_chk(8'h14, 32'h0, "R9 unmapped reads zero");

    // R10: writes to the mask offset and to status leave the mask alone
    step(1, 0, A_MASK, 32'h0, '0);
    rd_chk(A_MASK, 32'h2FF, "R10 write to mask offset ignored");
    step(1, 0, A_STAT, 32'hFFFF_FFFF, '0);
    rd_chk(A_MASK, 32'h2FF, "R10 status write leaves mask");

    // Per-bit sweep across all source positions
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] b;
      b = W'(1) << i;
      step(1, 0, A_UNM, 32'(b), '0);
      rd_chk(A_MASK, 32'(m_mask), $sformatf("R6 unmask bit %0d", i));
      if (!VALID[i]) begin
        step(0, 0, A_STAT, '0, b);
        rd_chk(A_STAT, 32'h0, "R9 bit 8 event ignored");
        check({31'b0, irq_o}, 32'd0, "R9 bit 8 no irq");
      end else if (LEVEL[i]) begin
        hold = b;
        step(0, 0, A_STAT, '0, '0);
        check({31'b0, irq_o}, 32'd1, $sformatf("R8 level bit %0d irq", i));
        step(1, 0, A_STAT, 32'(b), '0);
        rd_chk(A_STAT, 32'(b), $sformatf("R5 level bit %0d not cleared by write", i));
        hold = '0;
        step(0, 0, A_STAT, '0, '0);
        rd_chk(A_STAT, 32'h0, $sformatf("R5 level bit %0d follows drop", i));
        check({31'b0, irq_o}, 32'd0, $sformatf("R8 level bit %0d irq drop", i));
      end else begin
        step(0, 0, A_STAT, '0, b);
        check({31'b0, irq_o}, 32'd1, $sformatf("R8 sticky bit %0d irq same edge", i));
        rd_chk(A_STAT, 32'(b), $sformatf("R2 sticky bit %0d held", i));
        step(1, 0, A_STAT, 32'(~b), '0);
        rd_chk(A_STAT, 32'(b), $sformatf("R3 bit %0d write zero keeps", i));
        step(1, 0, A_STAT, 32'(b), b);
        rd_chk(A_STAT, 32'(b), $sformatf("R4 bit %0d event beats clear", i));
        step(1, 0, A_DOM, 32'(b), '0);
        check({31'b0, irq_o}, 32'd0, $sformatf("R7 bit %0d masked drops irq", i));
        rd_chk(A_MASK, 32'(m_mask), $sformatf("R7 mask bit %0d set", i));
        step(1, 0, A_UNM, 32'(b), '0);
        check({31'b0, irq_o}, 32'd1, $sformatf("R8 bit %0d unmasked irq", i));
        step(1, 0, A_STAT, 32'(b), '0);
        rd_chk(A_STAT, 32'h0, $sformatf("R3 bit %0d cleared", i));
        check({31'b0, irq_o}, {31'b0, exp_irq()}, $sformatf("R8 bit %0d irq after clear", i));
      end
    end

    // R6/R7 wide patterns, and R11 read returns pre-edge value
    step(1, 0, A_UNM, 32'h0, '0);
    rd_chk(A_MASK, 32'(m_mask), "R6 zero enable write keeps mask");
    step(1, 0, A_DOM, 32'hFFFF_FFFF, '0);
    rd_chk(A_MASK, 32'h2FF, "R7 all-ones disable, bit 8 reads 0");
    step(1, 0, A_UNM, 32'hFFFF_FFFF, '0);
    rd_chk(A_MASK, 32'h0, "R6 all-ones enable");
    step(0, 0, A_STAT, '0, 10'h03D);
    check({31'b0, irq_o}, 32'd1, "R8 several sources");
    step(0, 1, A_STAT, 32'h0, 10'h200);
    check(rdata, 32'h03D, "R11 read returns pre-edge status");
    step(0, 0, A_STAT, '0, '0);
    check(rdata, 32'h03D, "R11 rdata holds without read");
    rd_chk(A_STAT, 32'h23D, "R2 later event adds bit 9");
    step(1, 0, A_STAT, 32'h0000_0021, '0);
    rd_chk(A_STAT, 32'h21C, "R3 multi-bit clear");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule